// File: doc/BRIEF.md
# Packet Header ECC Encoder and Checker

This block protects the first three bytes of a serial display link packet header with an eight-bit error correction code. Each header is 32 bits wide: the data identifier byte sits in bits 7:0, the two data or word-count bytes sit in bits 15:8 and 23:16, and the code byte sits in bits 31:24. Data bit Dn is header bit n, so D0 is the least significant bit of the data identifier and D23 is the most significant bit of the third byte.

In encode mode the block takes the 24 data bits and puts the generated code byte above them. In check mode it takes a received 32-bit header and recomputes the code. It then forms the syndrome, which is the received code XOR the recomputed code. A zero syndrome means the header is clean. If the syndrome equals the column of one data bit, that bit is flipped. If the syndrome has exactly one bit set, only the code byte was hit. Any other syndrome is reported as uncorrectable. The result is registered and appears one clock after the request. It comes with the virtual channel and data type fields split out of the (corrected) identifier byte.

A five-state machine holds the kind of the last result. `ST_IDLE` means no result. `ST_ENCODED` holds an encode result. `ST_CLEAN` holds a check with a zero syndrome. `ST_FIXED` holds a check with a single corrected error. `ST_FAILED` holds a check with an uncorrectable error. On every clock the next state is chosen from the present request alone:
- no request → `ST_IDLE`
- encode request → `ST_ENCODED`
- check with a zero syndrome → `ST_CLEAN`
- check with a data-bit column or single-bit syndrome → `ST_FIXED`
- any other check → `ST_FAILED`

So each state can be reached from every state.

Top module: `hdr_ecc_unit`

## Requirements
- R1: A result appears exactly one clock after a request: `out_valid` is high in the cycle after `in_valid` was sampled high and low in the cycle after it was sampled low.
- R2: In encode mode `out_hdr[23:0]` equals `in_hdr[23:0]`, and `out_hdr[29:24]` is the XOR, over every data bit Dn that is 1, of that bit's column code (ECC bit 0 is the code's LSB). The codes are: D0 07h, D1 0Bh, D2 0Dh, D3 0Eh, D4 13h, D5 15h, D6 16h, D7 19h, D8 1Ah, D9 1Ch, D10 23h, D11 25h, D12 26h, D13 29h, D14 2Ah, D15 2Ch, D16 31h, D17 32h, D18 34h, D19 38h, D20 1Fh, D21 2Fh, D22 37h, D23 3Bh.
- R3: Bits 7:6 of every code byte the block generates are 0.
- R4: A check of a header whose code byte matches its data returns that header unchanged, with both error flags low.
- R5: A check of a header with exactly one flipped data bit returns the original data, with a regenerated code byte, `out_corrected` high and `out_uncorrectable` low.
- R6: A check of a header with exactly one flipped bit in the code byte (bits 31:24, including bits 31 and 30) returns the data unchanged with a regenerated code byte and `out_corrected` high.
- R7: A check whose syndrome is neither zero, nor a data-bit column, nor a single set bit (for example any two-bit error) raises `out_uncorrectable`, keeps `out_corrected` low and returns the received header unchanged. The two flags are never high together.
- R8: While `out_valid` is high, `out_vc` equals `out_hdr[7:6]` and `out_dtype` equals `out_hdr[5:0]`.
- R9: While `out_valid` is low, both error flags are low, whatever the inputs carried.
- R10: During and after reset, before any request, `out_valid`, both flags and `out_hdr` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Request present this cycle |
| in_check | input | 1 | 1 = check received header, 0 = encode |
| in_hdr | input | 32 | Header; bits 31:24 used only in check mode |
| out_valid | output | 1 | Result present |
| out_hdr | output | 32 | Encoded or corrected header |
| out_vc | output | 2 | Virtual channel field of the result |
| out_dtype | output | 6 | Data type field of the result |
| out_corrected | output | 1 | A single error was corrected |
| out_uncorrectable | output | 1 | Error could not be corrected |

## Verification
A wrong state register shows up as a wrong flag pair or a wrong `out_valid` in the very next cycle. For example, a fixed header marked clean, or a result left standing after the request goes away. A wrong column code or a wrong syndrome decode shows up at once in the code byte of an encode. In check mode it appears as a wrong bit flipped, or as a false uncorrectable flag on a single error. The bench tests each of the 32 single-bit positions and a spread of two-bit errors against a brute-force model that looks for the nearest codeword, so any such error is seen on the cycle of that request.

// File: rtl/hdr_ecc_pkg.sv
package hdr_ecc_pkg;

    localparam int HDR_DATA_W = 24;
    localparam int HDR_ECC_W  = 8;
    localparam int HDR_W      = HDR_DATA_W + HDR_ECC_W;
    localparam int COL_W      = 6;
    localparam int VC_LSB     = 6;
    localparam int VC_W       = 2;
    localparam int DT_W       = 6;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ENCODED,
        ST_CLEAN,
        ST_FIXED,
        ST_FAILED
    } ecc_state_e;

    // Parity participation of each data bit; bit j set means parity j uses it.
    function automatic logic [COL_W-1:0] column_code(input int idx);
        logic [COL_W-1:0] c;
        case (idx)
            0:  c = 6'h07;
            1:  c = 6'h0B;
            2:  c = 6'h0D;
            3:  c = 6'h0E;
            4:  c = 6'h13;
            5:  c = 6'h15;
            6:  c = 6'h16;
            7:  c = 6'h19;
            8:  c = 6'h1A;
            9:  c = 6'h1C;
            10: c = 6'h23;
            11: c = 6'h25;
            12: c = 6'h26;
            13: c = 6'h29;
            14: c = 6'h2A;
            15: c = 6'h2C;
            16: c = 6'h31;
            17: c = 6'h32;
            18: c = 6'h34;
            19: c = 6'h38;
            20: c = 6'h1F;
            21: c = 6'h2F;
            22: c = 6'h37;
            23: c = 6'h3B;
            default: c = '0;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/hdr_ecc_gen.sv
module hdr_ecc_gen
    import hdr_ecc_pkg::*;
(
    input  logic [HDR_DATA_W-1:0] data,
    output logic [HDR_ECC_W-1:0]  ecc
);

    logic [COL_W-1:0] par;

    always_comb begin
        par = '0;
        for (int i = 0; i < HDR_DATA_W; i++) begin
            par = par ^ (column_code(i) & {COL_W{data[i]}});
        end
    end

    // Upper code bits are always zero.
    assign ecc = {{(HDR_ECC_W-COL_W){1'b0}}, par};

endmodule

// File: rtl/hdr_ecc_decode.sv
module hdr_ecc_decode
    import hdr_ecc_pkg::*;
(
    input  logic [HDR_ECC_W-1:0]  syndrome,
    output logic [HDR_DATA_W-1:0] flip_mask,
    output logic                  no_err,
    output logic                  ecc_only,
    output logic                  data_fix,
    output logic                  fail
);

    logic [HDR_DATA_W-1:0] hit;

    for (genvar g = 0; g < HDR_DATA_W; g++) begin : g_col
        localparam logic [COL_W-1:0] COL = column_code(g);
        assign hit[g] = (syndrome == {{(HDR_ECC_W-COL_W){1'b0}}, COL});
    end

    assign flip_mask = hit;
    assign no_err    = (syndrome == '0);
    assign ecc_only  = !no_err && ((syndrome & (syndrome - 1'b1)) == '0);
    assign data_fix  = |hit;
    assign fail      = !no_err && !ecc_only && !data_fix;

endmodule

// File: rtl/hdr_ecc_unit.sv
module hdr_ecc_unit
    import hdr_ecc_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  in_valid,
    input  logic                  in_check,
    input  logic [HDR_W-1:0]      in_hdr,
    output logic                  out_valid,
    output logic [HDR_W-1:0]      out_hdr,
    output logic [VC_W-1:0]       out_vc,
    output logic [DT_W-1:0]       out_dtype,
    output logic                  out_corrected,
    output logic                  out_uncorrectable
);

    ecc_state_e            state_q, state_d;
    logic [HDR_W-1:0]      hdr_q, hdr_d;
    logic [HDR_ECC_W-1:0]  ecc_rx, ecc_fix, syndrome;
    logic [HDR_DATA_W-1:0] flip_mask, fixed_data;
    logic                  dec_clean, dec_ecc_only, dec_data_fix, dec_fail;

    hdr_ecc_gen u_gen_rx (
        .data (in_hdr[HDR_DATA_W-1:0]),
        .ecc  (ecc_rx)
    );

    assign syndrome = in_hdr[HDR_W-1:HDR_DATA_W] ^ ecc_rx;

    hdr_ecc_decode u_dec (
        .syndrome  (syndrome),
        .flip_mask (flip_mask),
        .no_err    (dec_clean),
        .ecc_only  (dec_ecc_only),
        .data_fix  (dec_data_fix),
        .fail      (dec_fail)
    );

    assign fixed_data = in_hdr[HDR_DATA_W-1:0] ^ flip_mask;

    hdr_ecc_gen u_gen_fix (
        .data (fixed_data),
        .ecc  (ecc_fix)
    );

    // Next state and next result
    always_comb begin
        state_d = ST_IDLE;
        hdr_d   = hdr_q;
        if (in_valid) begin
            if (!in_check) begin
                state_d = ST_ENCODED;
                hdr_d   = {ecc_rx, in_hdr[HDR_DATA_W-1:0]};
            end else if (dec_clean) begin
                state_d = ST_CLEAN;
                hdr_d   = in_hdr;
            end else if (dec_fail) begin
                state_d = ST_FAILED;
                hdr_d   = in_hdr;
            end else begin
                state_d = ST_FIXED;
                hdr_d   = {ecc_fix, fixed_data};
            end
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            hdr_q   <= '0;
        end else begin
            state_q <= state_d;
            hdr_q   <= hdr_d;
        end
    end

    // Outputs from state
    always_comb begin
        out_valid         = 1'b0;
        out_corrected     = 1'b0;
        out_uncorrectable = 1'b0;
        unique case (state_q)
            ST_IDLE:    ;
            ST_ENCODED: out_valid = 1'b1;
            ST_CLEAN:   out_valid = 1'b1;
            ST_FIXED: begin
                out_valid     = 1'b1;
                out_corrected = 1'b1;
            end
            ST_FAILED: begin
                out_valid         = 1'b1;
                out_uncorrectable = 1'b1;
            end
            default:    ;
        endcase
    end

    assign out_hdr   = hdr_q;
    assign out_vc    = hdr_q[VC_LSB +: VC_W];
    assign out_dtype = hdr_q[DT_W-1:0];

    p_valid_rise_r1: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    p_valid_fall_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    p_enc_data_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_check) |=> (out_hdr[HDR_DATA_W-1:0] == $past(in_hdr[HDR_DATA_W-1:0])));
    p_top_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_uncorrectable) |-> (out_hdr[HDR_W-1:HDR_W-2] == 2'b00));
    p_one_flip_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(flip_mask));
    p_fail_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_check && dec_fail) |=> (out_hdr == $past(in_hdr)));
    p_flag_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(out_corrected && out_uncorrectable));

endmodule

// File: tb/hdr_ecc_unit_test.sv
module hdr_ecc_unit_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_check = 1'b0;
    logic [31:0] in_hdr = '0;
    logic        out_valid;
    logic [31:0] out_hdr;
    logic [1:0]  out_vc;
    logic [5:0]  out_dtype;
    logic        out_corrected;
    logic        out_uncorrectable;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    logic [31:0] lfsr = 32'h1234_5679;

    always #4 clk = ~clk;

    hdr_ecc_unit uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_check(in_check),
        .in_hdr(in_hdr), .out_valid(out_valid), .out_hdr(out_hdr),
        .out_vc(out_vc), .out_dtype(out_dtype), .out_corrected(out_corrected),
        .out_uncorrectable(out_uncorrectable)
    );

    function automatic logic [7:0] ref_ecc(input logic [23:0] d);
        int l0[14] = '{0,1,2,4,5,7,10,11,13,16,20,21,22,23};
        int l1[14] = '{0,1,3,4,6,8,10,12,14,17,20,21,22,23};
        int l2[13] = '{0,2,3,5,6,9,11,12,15,18,20,21,22};
        int l3[13] = '{1,2,3,7,8,9,13,14,15,19,20,21,23};
        int l4[13] = '{4,5,6,7,8,9,16,17,18,19,20,22,23};
        int l5[13] = '{10,11,12,13,14,15,16,17,18,19,21,22,23};
        logic [7:0] e = '0;
        foreach (l0[k]) e[0] ^= d[l0[k]];
        foreach (l1[k]) e[1] ^= d[l1[k]];
        foreach (l2[k]) e[2] ^= d[l2[k]];
        foreach (l3[k]) e[3] ^= d[l3[k]];
        foreach (l4[k]) e[4] ^= d[l4[k]];
        foreach (l5[k]) e[5] ^= d[l5[k]];
        return e;
    endfunction

    function automatic bit is_code(input logic [31:0] w);
        return ref_ecc(w[23:0]) == w[31:24];
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Drive one cycle at a negedge, compare at the next negedge.
    task automatic step(input bit v, input bit c, input logic [31:0] h);
        bit e_cor = 0, e_unc = 0;
        logic [31:0] e_hdr = h;
        string tag = "R9";
        if (v && !c) begin
            e_hdr = {ref_ecc(h[23:0]), h[23:0]};
            tag = "R2";
        end else if (v) begin
            if (is_code(h)) tag = "R4";
            else begin
                e_unc = 1;
                tag = "R7";
                for (int p = 0; p < 32; p++) begin
                    if (e_unc && is_code(h ^ (32'h1 << p))) begin
                        e_unc = 0;
                        e_cor = 1;
                        e_hdr = h ^ (32'h1 << p);
                        tag = (p < 24) ? "R5" : "R6";
                    end
                end
            end
        end
        in_valid = v; in_check = c; in_hdr = h;
        @(negedge clk);
        check(out_valid == v, "R1 valid", {31'd0, out_valid}, {31'd0, v});
        check(out_corrected == e_cor && out_uncorrectable == e_unc, {tag, " flags"},
              {30'd0, out_corrected, out_uncorrectable}, {30'd0, e_cor, e_unc});
        if (v) begin
            check(out_hdr == e_hdr, {tag, " hdr"}, out_hdr, e_hdr);
            check(out_hdr[31:30] == 2'b00 || e_unc, "R3 top bits", out_hdr, e_hdr);
            check(out_vc == e_hdr[7:6] && out_dtype == e_hdr[5:0], "R8 fields",
                  {24'd0, out_vc, out_dtype}, {24'd0, e_hdr[7:0]});
        end
    endtask

    function automatic logic [31:0] next_rand(input logic [31:0] s);
        return {s[30:0], s[31] ^ s[21] ^ s[1] ^ s[0]};
    endfunction

    initial begin
        #(8 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] w;
        repeat (3) @(negedge clk);
        // R10 reset state
        check(out_valid == 0 && out_corrected == 0 && out_uncorrectable == 0 && out_hdr == 0,
              "R10 reset", out_hdr, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check(out_valid == 0 && out_hdr == 0, "R10 after reset", out_hdr, 32'h0);
        // encode patterns (R2, R3)
        step(1, 0, 32'h0000_0000);
        step(1, 0, 32'hFF00_0000);
        step(1, 0, 32'h00FF_FFFF);
        for (int i = 0; i < 24; i++) step(1, 0, 32'h1 << i);
        // idle with garbage (R9)
        step(0, 1, 32'hDEAD_BEEF);
        step(0, 0, 32'h1234_5678);
        // clean checks (R4)
        for (int i = 0; i < 20; i++) begin
            lfsr = next_rand(lfsr);
            step(1, 1, {ref_ecc(lfsr[23:0]), lfsr[23:0]});
        end
        // every single-bit position (R5 data, R6 code byte incl. bits 31:30)
        for (int k = 0; k < 4; k++) begin
            lfsr = next_rand(lfsr);
            w = {ref_ecc(lfsr[23:0]), lfsr[23:0]};
            for (int p = 0; p < 32; p++) step(1, 1, w ^ (32'h1 << p));
        end
        // two-bit errors (R7)
        for (int k = 0; k < 60; k++) begin
            int a, b;
            lfsr = next_rand(lfsr);
            w = {ref_ecc(lfsr[23:0]), lfsr[23:0]};
            a = int'(lfsr[4:0]);
            b = (a + 1 + int'(lfsr[9:5]) % 31) % 32;
            step(1, 1, w ^ (32'h1 << a) ^ (32'h1 << b));
        end
        step(1, 1, 32'hC000_0000);
        // back-to-back mode mixes and a gap
        for (int i = 0; i < 40; i++) begin
            lfsr = next_rand(lfsr);
            step(lfsr[0] | lfsr[1], lfsr[2], lfsr);
        end
        step(0, 0, 32'h0);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule